// File: doc/BRIEF.md
# Indexed-Colour Palette Loader and Lookup

This block sits between a display memory fetcher and the pixel pipeline of an LCD controller. At the start of each enabled period it can take a palette off a 32-bit word stream, check the colour-depth code carried in the first entry, and write the entries into an on-chip lookup RAM. Each stream word carries two 16-bit entries. It then raises a loaded flag. In parallel, an 8-bit pixel index is converted to a 12-bit RGB colour through the same RAM, one clock after the index is presented.

A 2-bit mode input selects whether a palette is expected at all. A palette with a 16-entry depth code is short. A palette with any other legal code is 256 entries long. The stream length in words follows from that size, plus one extra word. In palette-only mode, a clear strobe from the host clears the loaded flag. In every mode, dropping the enable clears it.

Top module: `lcd_palette_lut`

## Requirements
- R1: While reset is asserted and after its release, `colour`, `paletteLoaded`, `bppCode` and `wordReady` are all zero.
- R2: `loadMode` is sampled in the cycle where `enable` is first seen high. Values 0 (palette then frame) and 1 (palette only) start a palette load, and `wordReady` goes high in the next cycle. Values 2 (frame only) and 3 start no load: `wordReady` stays low and the RAM is not written.
- R3: Bits [14:12] of the first accepted word form the depth code. Code 0, 1, 2 or 3 (1, 2, 4 or 8 bpp) means a 256-entry palette and a load of 129 words. Code 4 (12/16 bpp) means a 16-entry palette and a load of 9 words. `bppCode` shows the code of the last accepted legal header.
- R4: A header code of 5, 6 or 7 aborts the load. Nothing is written, `bppCode` is unchanged, `paletteLoaded` stays low, and later words are accepted and dropped.
- R5: In word k of a load, bits [15:0] are entry 2k and bits [31:16] are entry 2k+1. Bits [11:0] of each half are stored as red [11:8], green [7:4] and blue [3:0]. Bits [15:12] are never stored, and that includes the code bits of entry 0.
- R6: An entry whose index is not below the palette size (256 or 16) is not written, so the last word of a load leaves RAM unchanged beyond the palette.
- R7: `paletteLoaded` rises in the cycle after the last word of a load is accepted, and not earlier.
- R8: After the load completes, `wordReady` stays high and further words are accepted and dropped without changing the RAM.
- R9: A high `clearLoaded` clears `paletteLoaded` only when the load was started in mode 1, and is ignored in the other modes. If `clearLoaded` arrives in the same cycle that the load completes, the set wins. A low `enable` clears `paletteLoaded` in all modes and returns the loader to idle.
- R10: `colour` is the RAM entry addressed by `pixIdx` one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Controller enable; a low level returns the loader to idle |
| loadMode | input | 2 | 0 palette+frame, 1 palette only, 2/3 frame only |
| clearLoaded | input | 1 | Clear request for the loaded flag (honoured in palette-only mode) |
| wordIn | input | 32 | Palette stream word, two entries, lower half first |
| wordValid | input | 1 | Stream word valid |
| wordReady | output | 1 | Loader accepts a stream word |
| pixIdx | input | 8 | Pixel index for lookup |
| colour | output | 12 | Registered RGB 4:4:4 lookup result |
| paletteLoaded | output | 1 | Palette load complete flag |
| bppCode | output | 3 | Depth code of the last legal header |

## Verification
The bench builds the block with its default sizes: 256 entries, a 16-entry short palette and 12-bit colour. With these sizes a full 129-word load and a 9-word short load both run in a few hundred cycles. Both of them reach the boundary where the last word's second half falls outside the palette, so the test can show that entries 16 and 17 survive a short load that follows a long one. The defaults also make the flag's set/clear rules in modes 0 and 1, the illegal header, and the frame-only mode cheap to exercise one after another on the same palette contents.

// File: rtl/lcdpal_pkg.sv
package lcdpal_pkg;

  // Write strobes from the load control to the palette datapath
  typedef struct packed {
    logic wrLo;   // write lower half of the current word
    logic wrHi;   // write upper half of the current word
  } palStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_LOAD  = 2'd1,
    S_DRAIN = 2'd2,
    S_FRAME = 2'd3
  } loadState_t;

  localparam logic [2:0] CODE_SHORT = 3'd4;  // 12/16 bpp, short palette

endpackage

// File: rtl/lcdpal_ctrl.sv
module lcdpal_ctrl
  import lcdpal_pkg::*;
#(
  parameter int ENTRIES       = 256,
  parameter int SMALL_ENTRIES = 16,
  parameter int CNT_W         = $clog2(ENTRIES / 2 + 2),
  parameter int IDX_W         = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       loadMode,
  input  logic             clearLoaded,
  input  logic             wordValid,
  input  logic [2:0]       hdrCode,
  output logic             wordReady,
  output palStrobe_t       strobe,
  output logic [IDX_W-1:0] baseIdx,
  output logic             paletteLoaded,
  output logic [2:0]       bppCode
);

  // words per load = bytes/4 + 1, two bytes per entry
  localparam int BIG_WORDS   = ENTRIES / 2 + 1;
  localparam int SMALL_WORDS = SMALL_ENTRIES / 2 + 1;
  localparam logic [CNT_W-1:0] BIG_LAST   = CNT_W'(BIG_WORDS - 1);
  localparam logic [CNT_W-1:0] SMALL_LAST = CNT_W'(SMALL_WORDS - 1);
  localparam logic [IDX_W:0]   BIG_LIM    = (IDX_W + 1)'(ENTRIES);
  localparam logic [IDX_W:0]   SMALL_LIM  = (IDX_W + 1)'(SMALL_ENTRIES);

  loadState_t       state;
  logic [CNT_W-1:0] wordCnt;
  logic             paletteOnly;
  logic [2:0]       codeQ;

  logic       accept, isHeader, headerBad, lastWord, doWrite;
  logic [2:0] curCode;
  logic [IDX_W:0] loIdxExt, hiIdxExt, limit;

  assign wordReady = (state == S_LOAD) || (state == S_DRAIN);
  assign accept    = wordValid && wordReady;
  assign isHeader  = (wordCnt == '0);
  assign headerBad = hdrCode > CODE_SHORT;
  assign curCode   = isHeader ? hdrCode : codeQ;
  assign lastWord  = (curCode == CODE_SHORT) ? (wordCnt == SMALL_LAST)
                                             : (wordCnt == BIG_LAST);
  assign limit     = (curCode == CODE_SHORT) ? SMALL_LIM : BIG_LIM;

  assign baseIdx  = {wordCnt, 1'b0};
  assign loIdxExt = {1'b0, baseIdx};
  assign hiIdxExt = {1'b0, baseIdx[IDX_W-1:1], 1'b1};

  assign doWrite     = (state == S_LOAD) && accept && !(isHeader && headerBad);
  assign strobe.wrLo = doWrite && (loIdxExt < limit);
  assign strobe.wrHi = doWrite && (hiIdxExt < limit);
  assign bppCode     = codeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= S_IDLE;
      wordCnt       <= '0;
      paletteOnly   <= 1'b0;
      codeQ         <= '0;
      paletteLoaded <= 1'b0;
    end else if (!enable) begin
      state         <= S_IDLE;
      wordCnt       <= '0;
      paletteLoaded <= 1'b0;
    end else begin
      if (clearLoaded && paletteOnly && state != S_IDLE)
        paletteLoaded <= 1'b0;
      unique case (state)
        S_IDLE: begin
          wordCnt     <= '0;
          paletteOnly <= (loadMode == 2'd1);
          state       <= (loadMode[1] == 1'b0) ? S_LOAD : S_FRAME;
        end
        S_LOAD: begin
          if (accept) begin
            if (isHeader && headerBad) begin
              state <= S_DRAIN;
            end else begin
              if (isHeader) codeQ <= hdrCode;
              if (lastWord) begin
                paletteLoaded <= 1'b1;
                state         <= S_DRAIN;
              end else begin
                wordCnt <= wordCnt + 1'b1;
              end
            end
          end
        end
        S_DRAIN: state <= S_DRAIN;
        S_FRAME: state <= S_FRAME;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcdpal_data.sv
module lcdpal_data
  import lcdpal_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int COLOR_W = 12,
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 9,
  parameter int PIX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  palStrobe_t         strobe,
  input  logic [IDX_W-1:0]   baseIdx,
  input  logic [WORD_W-1:0]  wordIn,
  input  logic [PIX_W-1:0]   pixIdx,
  output logic [COLOR_W-1:0] colour
);

  localparam int HALF = WORD_W / 2;

  logic [COLOR_W-1:0] palMem [ENTRIES];
  logic [PIX_W-1:0]   loIdx, hiIdx;

  assign loIdx = baseIdx[PIX_W-1:0];
  assign hiIdx = {baseIdx[PIX_W-1:1], 1'b1};

  logic unusedBits;
  assign unusedBits = ^{baseIdx[IDX_W-1:PIX_W], wordIn[HALF-1:COLOR_W],
                        wordIn[WORD_W-1:HALF+COLOR_W]};

  // both halves of a word land in one cycle
  always_ff @(posedge clk) begin
    if (strobe.wrLo) palMem[loIdx] <= wordIn[COLOR_W-1:0];
    if (strobe.wrHi) palMem[hiIdx] <= wordIn[HALF+COLOR_W-1:HALF];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) colour <= '0;
    else       colour <= palMem[pixIdx];
  end

endmodule

// File: rtl/lcd_palette_lut.sv
module lcd_palette_lut
  import lcdpal_pkg::*;
#(
  parameter int ENTRIES       = 256,
  parameter int SMALL_ENTRIES = 16,
  parameter int COLOR_W       = 12,
  parameter int WORD_W        = 32,
  parameter int CODE_LSB      = 12,
  parameter int PIX_W         = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [1:0]         loadMode,
  input  logic               clearLoaded,
  input  logic [WORD_W-1:0]  wordIn,
  input  logic               wordValid,
  output logic               wordReady,
  input  logic [PIX_W-1:0]   pixIdx,
  output logic [COLOR_W-1:0] colour,
  output logic               paletteLoaded,
  output logic [2:0]         bppCode
);

  localparam int CNT_W = $clog2(ENTRIES / 2 + 2);
  localparam int IDX_W = CNT_W + 1;

  palStrobe_t       strobe;
  logic [IDX_W-1:0] baseIdx;

  lcdpal_ctrl #(
    .ENTRIES(ENTRIES), .SMALL_ENTRIES(SMALL_ENTRIES),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .loadMode(loadMode),
    .clearLoaded(clearLoaded), .wordValid(wordValid),
    .hdrCode(wordIn[CODE_LSB+2:CODE_LSB]), .wordReady(wordReady),
    .strobe(strobe), .baseIdx(baseIdx),
    .paletteLoaded(paletteLoaded), .bppCode(bppCode)
  );

  lcdpal_data #(
    .ENTRIES(ENTRIES), .COLOR_W(COLOR_W), .WORD_W(WORD_W),
    .IDX_W(IDX_W), .PIX_W(PIX_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseIdx(baseIdx),
    .wordIn(wordIn), .pixIdx(pixIdx), .colour(colour)
  );

endmodule

// File: rtl/lcd_palette_lut_chk.sv
module lcd_palette_lut_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       clearLoaded,
  input logic       wordValid,
  input logic       wordReady,
  input logic       paletteLoaded,
  input logic [2:0] bppCode
);

  // R2 / R9: a low enable sends the loader back to idle
  p_idle_not_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !wordReady);

  // R9: disabling always clears the flag
  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !paletteLoaded);

  // R9: without a clear request or disable the flag holds
  p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (paletteLoaded && enable && !clearLoaded) |=> paletteLoaded);

  // R7: the flag only rises right after a word handshake
  p_rise_after_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(paletteLoaded) |-> $past(wordValid && wordReady));

  // R3: the depth code only changes on an accepted word
  p_code_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(wordValid && wordReady) |=> $stable(bppCode));

endmodule

bind lcd_palette_lut lcd_palette_lut_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .clearLoaded(clearLoaded),
  .wordValid(wordValid), .wordReady(wordReady),
  .paletteLoaded(paletteLoaded), .bppCode(bppCode)
);

// File: tb/lcd_palette_lut_test.sv
module lcd_palette_lut_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  loadMode = 2'd0;
  logic        clearLoaded = 1'b0;
  logic [31:0] wordIn = '0;
  logic        wordValid = 1'b0;
  logic        wordReady;
  logic [7:0]  pixIdx = '0;
  logic [11:0] colour;
  logic        paletteLoaded;
  logic [2:0]  bppCode;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lcd_palette_lut uut (
    .clk(clk), .rstN(rstN), .enable(enable), .loadMode(loadMode),
    .clearLoaded(clearLoaded), .wordIn(wordIn), .wordValid(wordValid),
    .wordReady(wordReady), .pixIdx(pixIdx), .colour(colour),
    .paletteLoaded(paletteLoaded), .bppCode(bppCode)
  );

  // long-palette colour: red=n[7:4], green=n[3:0], blue=red^green
  function automatic logic [11:0] longCol(input logic [7:0] n);
    return {n[7:4], n[3:0], n[7:4] ^ n[3:0]};
  endfunction

  // index / expected colour after the 8 bpp load (R5, R10)
  localparam logic [19:0] LOOKUP_TAB [8] = '{
    {8'h00, 12'h000}, {8'h01, 12'h011}, {8'h2A, 12'h2A8}, {8'h7F, 12'h7F8},
    {8'h80, 12'h808}, {8'hC3, 12'hC3F}, {8'hFE, 12'hFE1}, {8'hFF, 12'hFF0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    @(negedge clk);
    wordIn = w;
    wordValid = 1'b1;
    while (!wordReady) @(negedge clk);
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic lookup(input logic [7:0] idx, input logic [11:0] exp, input string req);
    @(negedge clk);
    pixIdx = idx;
    @(negedge clk);
    check(colour == exp, req, colour, exp);
  endtask

  task automatic stepTo(input bit en, input logic [1:0] mode);
    @(negedge clk);
    loadMode = mode;
    enable = en;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check(colour == 12'h000 && !paletteLoaded && !wordReady && bppCode == 3'd0,
          "R1", {paletteLoaded, wordReady, colour}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!paletteLoaded && !wordReady && bppCode == 3'd0, "R1",
          {paletteLoaded, wordReady, bppCode}, 0);

    // R2/R3/R5: 8 bpp load in mode 0, junk upper nibbles
    stepTo(1'b1, 2'd0);
    for (int k = 0; k < 128; k++) begin
      logic [15:0] lo, hi;
      lo = (k == 0) ? {4'h3, longCol(8'(2 * k))} : {4'hA, longCol(8'(2 * k))};
      hi = {4'hA, longCol(8'(2 * k + 1))};
      sendWord({hi, lo});
    end
    check(!paletteLoaded, "R7 early", paletteLoaded, 0);
    sendWord(32'h0EEE_0DDD);  // entries 256/257: outside palette (R6)
    check(paletteLoaded, "R7 set", paletteLoaded, 1);
    check(bppCode == 3'd3, "R3 code3", bppCode, 3);

    for (int i = 0; i < 8; i++)
      lookup(LOOKUP_TAB[i][19:12], LOOKUP_TAB[i][11:0], "R5 lookup");

    // R10: colour follows index one clock later
    @(negedge clk);
    pixIdx = 8'h10;
    #1 check(colour == 12'hFF0, "R10 old", colour, 12'hFF0);
    @(negedge clk);
    check(colour == longCol(8'h10), "R10 new", colour, longCol(8'h10));

    // R8: surplus word accepted and dropped
    check(wordReady, "R8 ready", wordReady, 1);
    sendWord(32'h0FFF_0FFF);
    lookup(8'h00, 12'h000, "R8 entry0");
    lookup(8'h01, 12'h011, "R8 entry1");

    // R9: clear ignored in mode 0, disable clears
    @(negedge clk);
    clearLoaded = 1'b1;
    @(negedge clk);
    clearLoaded = 1'b0;
    check(paletteLoaded, "R9 mode0 clear ignored", paletteLoaded, 1);
    stepTo(1'b0, 2'd0);
    @(negedge clk);
    check(!paletteLoaded && !wordReady, "R9 disable", {paletteLoaded, wordReady}, 0);

    // R3/R6: short palette in mode 1
    stepTo(1'b1, 2'd1);
    for (int k = 0; k < 9; k++) begin
      logic [15:0] lo, hi;
      if (k == 8) begin
        lo = 16'h0EEE; hi = 16'h0EEE;
      end else begin
        lo = (k == 0) ? 16'h45A0 : {4'hB, 8'h5A, 4'(2 * k)};
        hi = {4'hC, 8'h5A, 4'(2 * k + 1)};
      end
      if (k == 8) check(!paletteLoaded, "R7 short early", paletteLoaded, 0);
      sendWord({hi, lo});
    end
    check(paletteLoaded, "R7 short set", paletteLoaded, 1);
    check(bppCode == 3'd4, "R3 code4", bppCode, 4);
    lookup(8'h05, 12'h5A5, "R3 short entry5");
    lookup(8'h0E, 12'h5AE, "R5 short entry14");
    lookup(8'h10, longCol(8'h10), "R6 entry16 kept");
    lookup(8'h11, longCol(8'h11), "R6 entry17 kept");
    lookup(8'hC8, 12'hC84, "R3 entry200 kept");

    // R9: clear honoured in mode 1
    @(negedge clk);
    clearLoaded = 1'b1;
    @(negedge clk);
    clearLoaded = 1'b0;
    check(!paletteLoaded, "R9 mode1 clear", paletteLoaded, 0);
    stepTo(1'b0, 2'd1);

    // R4: illegal header code 6
    stepTo(1'b1, 2'd1);
    sendWord(32'h0FFF_6123);
    sendWord(32'h0FFF_0FFF);
    check(!paletteLoaded, "R4 no flag", paletteLoaded, 0);
    check(bppCode == 3'd4, "R4 code kept", bppCode, 4);
    check(wordReady, "R4 draining", wordReady, 1);
    lookup(8'h00, 12'h5A0, "R4 entry0 kept");
    lookup(8'h01, 12'h5A1, "R4 entry1 kept");
    stepTo(1'b0, 2'd1);

    // R2: frame-only mode loads nothing
    stepTo(1'b1, 2'd2);
    @(negedge clk);
    wordIn = 32'h4FFF_4FFF;
    wordValid = 1'b1;
    repeat (3) @(negedge clk);
    check(!wordReady, "R2 frame-only ready", wordReady, 0);
    wordValid = 1'b0;
    check(!paletteLoaded, "R2 frame-only flag", paletteLoaded, 0);
    lookup(8'h02, 12'h5A2, "R2 frame-only entry2");
    stepTo(1'b0, 2'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule